// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This unit holds the status word of one descriptor-driven DMA channel and gives software a way to change that word. The status word has seven single-bit flags: run, pause, flush, wake, dead, active and branch-taken. It also has a device status field of up to eight bits. Each flag is brought out to the channel sequencer as a separate signal. The sequencer sends back set and clear requests for the active, dead and branch-taken flags, and a done strobe for a flush.

Software never writes the status word directly. It writes a control word instead. The upper sixteen bits of that word select which status bits change, and the lower sixteen bits give their new values. A single flag can therefore be started, stopped or cleared without first reading the word back. Two control words are the usual way to stop a channel:

- A stop masks run and flush and writes zero to both.
- A channel reset masks all six lifecycle flags and writes zero to them.

The register bus is a single-cycle valid/write/address/data port with registered read data.

Top module: `dmachan_csr`

## Requirements
- R1: A synchronous reset drives every status bit, the device status field, `seq_start`, `bus_rdata` and `bus_rvalid` to 0.
- R2: A write to the control address (byte address 0x0) changes status bit i (i in 0..15) only where `bus_wdata[16+i]` is 1. The new value is `bus_wdata[i]`. Bits whose mask bit is 0 keep their value. The new value shows on the flag outputs in the cycle after the write edge.
- R3: Status word layout:
  - bit 15 run, bit 14 pause, bit 13 flush, bit 12 wake;
  - bit 11 dead, bit 10 active, bit 8 branch-taken;
  - bits 7:0 device status.
  Bit 9 always reads 0 and ignores writes.
- R4: A write to the status address (0x4), or to any address other than 0x0, leaves the status word unchanged.
- R5: A read of address 0x0 or 0x4 returns {16'h0, status} on `bus_rdata`, with `bus_rvalid` high one cycle after the request. A read of any other address returns 0, also with `bus_rvalid` high. `bus_rvalid` is low in the cycle after any cycle with no read. The word is little-endian: bits 7:0 are the lowest-addressed byte.
- R6: The stop word 0xA000_0000 clears run and flush and leaves every other bit unchanged.
- R7: The channel-reset word 0xFC00_0000 clears run, pause, flush, wake, dead and active. Branch-taken and the device status field keep their values.
- R8: `seq_start` is high for exactly one cycle, in the first cycle that run reads 1 after reading 0, and only if pause reads 0 in that cycle. It does not pulse again while run stays 1.
- R9: Flush reads 0 in the cycle after `seq_flush_done` is sampled 1. This holds even when a control write sets flush in the same cycle.
- R10: A hardware set or clear request for active, dead or branch-taken takes effect in the next cycle and overrides a control write in the same cycle. If set and clear are both high, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus request valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data; for control: mask in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| ch_run | output | 1 | Run flag |
| ch_pause | output | 1 | Pause flag |
| ch_flush | output | 1 | Flush flag |
| ch_wake | output | 1 | Wake flag |
| ch_dead | output | 1 | Dead flag |
| ch_active | output | 1 | Active flag |
| ch_bt | output | 1 | Branch-taken flag |
| ch_devstat | output | DEVSTAT_W (8) | Device status field |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_flush_done | input | 1 | Sequencer reports that the flush is complete |
| hw_set_active | input | 1 | Sequencer sets active |
| hw_clr_active | input | 1 | Sequencer clears active |
| hw_set_dead | input | 1 | Sequencer sets dead |
| hw_clr_dead | input | 1 | Sequencer clears dead |
| hw_set_bt | input | 1 | Sequencer sets branch-taken |
| hw_clr_bt | input | 1 | Sequencer clears branch-taken |

## Verification
These results are due one clock edge after their stimulus:

- every flag change from a control write, a hardware request or a flush-done strobe;
- the `seq_start` pulse;
- read data together with `bus_rvalid`.

The bench drives each stimulus at a falling edge so that exactly one rising edge captures it. It samples at the next falling edge, so every check looks at the cycle in which the result first appears. The start pulse is sampled in that same cycle, and a later sample confirms it has gone. Reads are issued only after the write has settled, so a read shows the value already seen on the flag outputs.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

   localparam int unsigned STAT_W = 16;

   localparam int B_RUN    = 15;
   localparam int B_PAUSE  = 14;
   localparam int B_FLUSH  = 13;
   localparam int B_WAKE   = 12;
   localparam int B_DEAD   = 11;
   localparam int B_ACTIVE = 10;
   localparam int B_RSVD   = 9;
   localparam int B_BT     = 8;

   // Bits the sequencer may set or clear directly
   function automatic bit hw_owned(input int b);
      return (b == B_DEAD) || (b == B_ACTIVE) || (b == B_BT);
   endfunction

   // Bits cleared by a sequencer acknowledge
   function automatic bit ack_cleared(input int b);
      return (b == B_FLUSH);
   endfunction

endpackage

// File: rtl/dmachan_flag_cell.sv
module dmachan_flag_cell #(
   parameter bit HW_EN  = 1'b0,
   parameter bit ACK_EN = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic wr_en,
   input  logic wr_val,
   input  logic hw_set,
   input  logic hw_clr,
   input  logic ack,
   output logic q
);

   logic set_g, clr_g, ack_g;

   generate
      if (HW_EN) begin : g_hw
         assign set_g = hw_set;
         assign clr_g = hw_clr;
      end else begin : g_nohw
         logic unused_hw;
         assign unused_hw = hw_set ^ hw_clr;
         assign set_g = 1'b0;
         assign clr_g = 1'b0;
      end

      if (ACK_EN) begin : g_ack
         assign ack_g = ack;
      end else begin : g_noack
         logic unused_ack;
         assign unused_ack = ack;
         assign ack_g = 1'b0;
      end
   endgenerate

   // Priority: hardware set, hardware clear, acknowledge, software write
   always_ff @(posedge clk) begin
      if (rst)        q <= 1'b0;
      else if (set_g) q <= 1'b1;
      else if (clr_g) q <= 1'b0;
      else if (ack_g) q <= 1'b0;
      else if (wr_en) q <= wr_val;
   end

   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !set_g && !clr_g && !ack_g) |=> $stable(q));

   generate
      if (HW_EN) begin : g_hw_chk
         a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
            hw_set |=> q);
         a_r10_clr_over_write: assert property (@(posedge clk) disable iff (rst)
            (hw_clr && !hw_set) |=> !q);
      end
      if (ACK_EN) begin : g_ack_chk
         a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
            ack |=> !q);
      end
   endgenerate

endmodule

// File: rtl/dmachan_start_gen.sv
module dmachan_start_gen (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic pause,
   output logic start
);

   logic run_d;

   always_ff @(posedge clk) begin
      if (rst) run_d <= 1'b0;
      else     run_d <= run;
   end

   assign start = run & ~run_d & ~pause;

   a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
      start |=> !start);
   a_r8_not_paused: assert property (@(posedge clk) disable iff (rst)
      start |-> (run && !pause));

endmodule

// File: rtl/dmachan_rdport.sv
module dmachan_rdport #(
   parameter int unsigned ADDR_W = 4,
   parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
   parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       stat,
   output logic [31:0]       rdata,
   output logic              rvalid
);

   logic rd_req, rd_hit;

   assign rd_req = bus_valid & ~bus_write;
   assign rd_hit = (bus_addr == CTRL_OFS) || (bus_addr == STAT_OFS);

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_req;
         if (rd_req) rdata <= rd_hit ? {16'h0000, stat} : 32'h0;
      end
   end

   a_r5_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
      rd_req |=> rvalid);
   a_r5_rvalid_quiet: assert property (@(posedge clk) disable iff (rst)
      !rd_req |=> !rvalid);

endmodule

// File: rtl/dmachan_csr.sv
module dmachan_csr
   import dmachan_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DEVSTAT_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_OFS = '0,
   parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 bus_rvalid,
   output logic                 ch_run,
   output logic                 ch_pause,
   output logic                 ch_flush,
   output logic                 ch_wake,
   output logic                 ch_dead,
   output logic                 ch_active,
   output logic                 ch_bt,
   output logic [DEVSTAT_W-1:0] ch_devstat,
   output logic                 seq_start,
   input  logic                 seq_flush_done,
   input  logic                 hw_set_active,
   input  logic                 hw_clr_active,
   input  logic                 hw_set_dead,
   input  logic                 hw_clr_dead,
   input  logic                 hw_set_bt,
   input  logic                 hw_clr_bt
);

   localparam int unsigned MASK_LSB = STAT_W;

   generate
      if (DEVSTAT_W < 1 || DEVSTAT_W > 8) begin : g_bad_devstat
         $error("dmachan_csr: DEVSTAT_W must be 1..8");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("dmachan_csr: ADDR_W must be at least 3");
      end
      if (CTRL_OFS == STAT_OFS) begin : g_bad_ofs
         $error("dmachan_csr: control and status offsets must differ");
      end
   endgenerate

   logic [STAT_W-1:0] stat;
   logic [STAT_W-1:0] hw_set_v, hw_clr_v, ack_v;
   logic              wr_ctrl;

   assign wr_ctrl = bus_valid & bus_write & (bus_addr == CTRL_OFS);

   always_comb begin
      hw_set_v           = '0;
      hw_clr_v           = '0;
      ack_v              = '0;
      hw_set_v[B_ACTIVE] = hw_set_active;
      hw_clr_v[B_ACTIVE] = hw_clr_active;
      hw_set_v[B_DEAD]   = hw_set_dead;
      hw_clr_v[B_DEAD]   = hw_clr_dead;
      hw_set_v[B_BT]     = hw_set_bt;
      hw_clr_v[B_BT]     = hw_clr_bt;
      ack_v[B_FLUSH]     = seq_flush_done;
   end

   generate
      for (genvar i = 0; i < STAT_W; i++) begin : g_bit
         if (i == B_RSVD || (i < 8 && i >= DEVSTAT_W)) begin : g_none
            logic unused_b;
            assign unused_b = ^{bus_wdata[i], bus_wdata[MASK_LSB+i],
                                hw_set_v[i], hw_clr_v[i], ack_v[i]};
            assign stat[i] = 1'b0;
         end else begin : g_cell
            dmachan_flag_cell #(
               .HW_EN  (hw_owned(i)),
               .ACK_EN (ack_cleared(i))
            ) u_cell (
               .clk    (clk),
               .rst    (rst),
               .wr_en  (wr_ctrl & bus_wdata[MASK_LSB+i]),
               .wr_val (bus_wdata[i]),
               .hw_set (hw_set_v[i]),
               .hw_clr (hw_clr_v[i]),
               .ack    (ack_v[i]),
               .q      (stat[i])
            );
         end
      end
   endgenerate

   assign ch_run     = stat[B_RUN];
   assign ch_pause   = stat[B_PAUSE];
   assign ch_flush   = stat[B_FLUSH];
   assign ch_wake    = stat[B_WAKE];
   assign ch_dead    = stat[B_DEAD];
   assign ch_active  = stat[B_ACTIVE];
   assign ch_bt      = stat[B_BT];
   assign ch_devstat = stat[DEVSTAT_W-1:0];

   generate
      if (DEVSTAT_W < 8) begin : g_devpad
         logic unused_pad;
         assign unused_pad = ^stat[7:DEVSTAT_W];
      end
   endgenerate

   dmachan_start_gen u_start (
      .clk   (clk),
      .rst   (rst),
      .run   (stat[B_RUN]),
      .pause (stat[B_PAUSE]),
      .start (seq_start)
   );

   dmachan_rdport #(
      .ADDR_W   (ADDR_W),
      .CTRL_OFS (CTRL_OFS),
      .STAT_OFS (STAT_OFS)
   ) u_rd (
      .clk       (clk),
      .rst       (rst),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .stat      (stat),
      .rdata     (bus_rdata),
      .rvalid    (bus_rvalid)
   );

   logic any_hw;
   assign any_hw = |{hw_set_v, hw_clr_v, ack_v};

   a_r4_other_write_ignored: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && bus_write && bus_addr != CTRL_OFS && !any_hw) |=> $stable(stat));
   a_r3_rsvd_untouched: assert property (@(posedge clk) disable iff (rst)
      wr_ctrl |=> (bus_rdata[B_RSVD] == 1'b0));

endmodule

// File: tb/sim_dmachan_csr.sv
`timescale 1ns/1ps
module sim_dmachan_csr;

   logic        clk = 1'b0;
   logic        rst;
   logic        bus_valid, bus_write;
   logic [3:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        bus_rvalid;
   logic        ch_run, ch_pause, ch_flush, ch_wake, ch_dead, ch_active, ch_bt;
   logic [7:0]  ch_devstat;
   logic        seq_start, seq_flush_done;
   logic        hw_set_active, hw_clr_active, hw_set_dead, hw_clr_dead;
   logic        hw_set_bt, hw_clr_bt;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dmachan_csr u0 (
      .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .ch_run(ch_run), .ch_pause(ch_pause),
      .ch_flush(ch_flush), .ch_wake(ch_wake), .ch_dead(ch_dead),
      .ch_active(ch_active), .ch_bt(ch_bt), .ch_devstat(ch_devstat),
      .seq_start(seq_start), .seq_flush_done(seq_flush_done),
      .hw_set_active(hw_set_active), .hw_clr_active(hw_clr_active),
      .hw_set_dead(hw_set_dead), .hw_clr_dead(hw_clr_dead),
      .hw_set_bt(hw_set_bt), .hw_clr_bt(hw_clr_bt)
   );

   function automatic logic [15:0] stat_o();
      return {ch_run, ch_pause, ch_flush, ch_wake, ch_dead, ch_active,
              1'b0, ch_bt, ch_devstat};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata; v = bus_rvalid;
   endtask

   // {addr[4], wdata[32], expected status[16], expected start[1]}
   localparam logic [52:0] VECS [0:15] = '{
      {4'h0, 32'h00FF_00A5, 16'h00A5, 1'b0},  // R2 device field only
      {4'h0, 32'h1000_1000, 16'h10A5, 1'b0},  // R3 wake at bit 12
      {4'h0, 32'h000F_0000, 16'h10A0, 1'b0},  // R2 partial mask clear
      {4'h4, 32'hFFFF_FFFF, 16'h10A0, 1'b0},  // R4 status write ignored
      {4'h0, 32'h0200_0200, 16'h10A0, 1'b0},  // R3 bit 9 reserved
      {4'h0, 32'h4000_4000, 16'h50A0, 1'b0},  // R3 pause
      {4'h0, 32'h8000_8000, 16'hD0A0, 1'b0},  // R8 run while paused: no start
      {4'h0, 32'h2000_2000, 16'hF0A0, 1'b0},  // R3 flush
      {4'h0, 32'hA000_0000, 16'h50A0, 1'b0},  // R6 stop word
      {4'h0, 32'h4000_0000, 16'h10A0, 1'b0},  // R2 unpause
      {4'h0, 32'h8000_FFFF, 16'h90A0, 1'b1},  // R8 run rises, start pulse
      {4'h0, 32'h8000_8000, 16'h90A0, 1'b0},  // R8 run held, no pulse
      {4'h0, 32'h0D00_0D00, 16'h9DA0, 1'b0},  // R3 dead/active/bt
      {4'h0, 32'hFC00_0000, 16'h01A0, 1'b0},  // R7 channel reset word
      {4'h0, 32'h0000_FFFF, 16'h01A0, 1'b0},  // R2 empty mask
      {4'h8, 32'hFFFF_FFFF, 16'h01A0, 1'b0}   // R4 other address ignored
   };

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic        v;
      rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
      seq_flush_done = 1'b0;
      hw_set_active = 1'b0; hw_clr_active = 1'b0; hw_set_dead = 1'b0;
      hw_clr_dead = 1'b0; hw_set_bt = 1'b0; hw_clr_bt = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      check("R1 reset status", {16'h0, stat_o()}, 32'h0);
      check("R1 reset start", {31'h0, seq_start}, 32'h0);
      check("R1 reset rdata", bus_rdata, 32'h0);
      check("R1 reset rvalid", {31'h0, bus_rvalid}, 32'h0);

      for (int k = 0; k < 16; k++) begin
         wr(VECS[k][52:49], VECS[k][48:17]);
         check($sformatf("R2 table vec %0d status", k), {16'h0, stat_o()}, {16'h0, VECS[k][16:1]});
         check($sformatf("R8 table vec %0d start", k), {31'h0, seq_start}, {31'h0, VECS[k][0]});
         rd(4'h4, d, v);
         check($sformatf("R5 table vec %0d read", k), d, {16'h0, VECS[k][16:1]});
         check($sformatf("R8 table vec %0d start gone", k), {31'h0, seq_start}, 32'h0);
      end

      // R5 read of control address and unmapped address
      rd(4'h0, d, v);
      check("R5 control read data", d, 32'h0000_01A0);
      check("R5 control read valid", {31'h0, v}, 32'h1);
      rd(4'hC, d, v);
      check("R5 unmapped read data", d, 32'h0);
      check("R5 unmapped read valid", {31'h0, v}, 32'h1);
      @(negedge clk);
      check("R5 rvalid low when idle", {31'h0, bus_rvalid}, 32'h0);

      // R9 flush self-clear on acknowledge
      wr(4'h0, 32'h2000_2000);
      check("R9 flush set", {31'h0, ch_flush}, 32'h1);
      seq_flush_done = 1'b1;
      @(negedge clk);
      seq_flush_done = 1'b0;
      check("R9 flush cleared by done", {31'h0, ch_flush}, 32'h0);
      seq_flush_done = 1'b1;
      wr(4'h0, 32'h2000_2000);
      seq_flush_done = 1'b0;
      check("R9 done beats write", {31'h0, ch_flush}, 32'h0);

      // R10 hardware requests over software writes
      hw_set_active = 1'b1;
      wr(4'h0, 32'h0400_0000);
      hw_set_active = 1'b0;
      check("R10 set active beats sw clear", {31'h0, ch_active}, 32'h1);
      hw_clr_dead = 1'b1;
      wr(4'h0, 32'h0800_0800);
      hw_clr_dead = 1'b0;
      check("R10 clr dead beats sw set", {31'h0, ch_dead}, 32'h0);
      hw_clr_bt = 1'b1;
      @(negedge clk);
      hw_clr_bt = 1'b0;
      check("R10 clr bt", {31'h0, ch_bt}, 32'h0);
      hw_set_bt = 1'b1; hw_clr_bt = 1'b1;
      @(negedge clk);
      hw_set_bt = 1'b0; hw_clr_bt = 1'b0;
      check("R10 set wins over clr", {31'h0, ch_bt}, 32'h1);
      check("R10 other bits intact", {16'h0, stat_o()}, 32'h0000_05A0);

      // R1 reset in mid-operation
      wr(4'h0, 32'hF000_F000);
      rd(4'h4, d, v);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 mid reset status", {16'h0, stat_o()}, 32'h0);
      check("R1 mid reset rdata", bus_rdata, 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule